// File: doc/BRIEF.md
# External Clock Pin Interface

This block links six external clock pins to six internal global clock-source lines, one pin per line. Each channel is set up on its own at run time. A channel in input mode brings the pin into the clock domain through a two-stage synchronizer. It then looks for a selectable transition: rising, falling, either, or none. Each transition it finds becomes a single-cycle strobe on the channel's global line. A channel in output mode watches its global line. Every rising edge of that line starts a high pulse on the pin, and a per-channel setting can stretch the pulse beyond its base length.

The configuration arrives as plain vectors: one direction bit, one 2-bit edge selector and one width field per channel. Another block writes these. The pad cells take the pin output-enable and drive value from here and return the sampled pin level.

Top module: `ext_clk_pins`

## Requirements
- R1: After reset, every bit of `glb_out` and `pin_out` is 0.
- R2: `pin_oe[i]` equals `cfg_dir[i]` in the same cycle. A channel in output mode (`cfg_dir[i]`=1) never strobes `glb_out[i]`.
- R3: Edge code 2'b00 (rising). If a rising pin level is sampled at clock edge E, `glb_out[i]` is high for exactly the one cycle that follows edge E+2. A falling pin level gives no strobe.
- R4: Edge code 2'b01 (falling). A falling pin level gives the same single strobe, with the same timing as R3. A rising pin level gives none.
- R5: Edge code 2'b10 (both). Every change of the pin level gives one strobe, with the R3 timing.
- R6: Edge code 2'b11 (disabled). No pin change produces a strobe.
- R7: A pin that toggles on every clock cycle (half the clock rate) loses no qualifying edge. Twenty toggles give ten strobes in rising mode and twenty strobes in both mode.
- R8: In output mode, a rising edge of `glb_in[i]` sampled at clock edge E makes `pin_out[i]` high from edge E for 5 + `cfg_width` cycles. The base of 5 cycles is 25 ns at 200 MHz. `cfg_width` is the 4-bit field at bits [4i+3:4i].
- R9: A new rising edge of `glb_in[i]` while a pulse is still active restarts the full pulse length from that edge.
- R10: In input mode, `glb_in[i]` has no effect on `pin_out[i]`. Switching a channel to input mode in the middle of a pulse ends the pulse one cycle later.
- R11: The channels act independently. Simultaneous triggers with different widths give each pin its own pulse length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dir | input | 6 | Per-channel direction, 1 = output |
| cfg_edge | input | 12 | Per-channel 2-bit edge select for input mode |
| cfg_width | input | 24 | Per-channel 4-bit pulse extension for output mode |
| pin_in | input | 6 | Pin levels sampled from the pads |
| pin_out | output | 6 | Pin drive value in output mode |
| pin_oe | output | 6 | Pin output enable |
| glb_in | input | 6 | Global clock-source lines, read in output mode |
| glb_out | output | 6 | Global clock-source strobes produced in input mode |

## Verification
The timing of each result is fixed, so the bench samples at exact cycles. An input-mode strobe appears at the third falling clock edge after the pin is driven. An output pulse is high from the first falling edge after the trigger is driven until the (5 + width)th falling edge. A restart moves that end point forward by the distance between the two triggers. The bench drives inputs just after a falling edge and reads outputs at the following falling edges. It compares the whole output vector against a value computed from the channel number, the edge code and the width field, so a strobe or pulse that is one cycle early or late, or lands on the wrong channel, is caught.

// File: rtl/ext_clk_pkg.sv
package ext_clk_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_sel_e;

  // Decide whether a sampled transition (prv -> cur) qualifies under sel.
  function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prv);
    logic r;
    case (sel)
      EDGE_RISE: r = cur & ~prv;
      EDGE_FALL: r = ~cur & prv;
      EDGE_BOTH: r = cur ^ prv;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

  // Output pulse length in cycles: fixed base plus programmed extension.
  function automatic int unsigned pulse_len(int unsigned base, int unsigned ext);
    return base + ext;
  endfunction

endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge
  import ext_clk_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       evt
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign evt = edge_hit(edge_sel_e'(sel), chain[STAGES-1], chain[STAGES]);
endmodule

// File: rtl/pin_pulse_gen.sv
module pin_pulse_gen
  import ext_clk_pkg::*;
#(
  parameter int WW       = 4,
  parameter int BASE_CYC = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          trig,
  input  logic [WW-1:0] width,
  output logic          rise,
  output logic          pulse
);
  localparam int MAXLEN = BASE_CYC + (1 << WW) - 1;
  localparam int CW     = $clog2(MAXLEN + 1);

  logic          trig_q;
  logic          busy;
  logic [CW-1:0] cnt;

  assign rise  = trig & ~trig_q;
  assign pulse = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (rise) begin
      busy <= 1'b1;
      cnt  <= CW'(pulse_len(BASE_CYC, int'(width)) - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/ext_clk_lane.sv
module ext_clk_lane #(
  parameter int WW       = 4,
  parameter int BASE_CYC = 5,
  parameter int STAGES   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir,
  input  logic [1:0]    sel,
  input  logic [WW-1:0] width,
  input  logic          pin_i,
  input  logic          glb_i,
  output logic          pin_o,
  output logic          pin_en,
  output logic          glb_o,
  output logic          evt,
  output logic          rise
);
  logic strobe_q;

  pin_sync_edge #(.STAGES(STAGES)) u_det (
    .clk(clk), .rst_n(rst_n), .pin(pin_i), .sel(sel), .evt(evt)
  );

  pin_pulse_gen #(.WW(WW), .BASE_CYC(BASE_CYC)) u_gen (
    .clk(clk), .rst_n(rst_n), .en(dir), .trig(glb_i), .width(width),
    .rise(rise), .pulse(pin_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= evt & ~dir;
  end

  assign glb_o  = strobe_q;
  assign pin_en = dir;
endmodule

// File: rtl/ext_clk_pins.sv
module ext_clk_pins #(
  parameter int N_CH     = 6,
  parameter int WW       = 4,
  parameter int BASE_CYC = 5,
  parameter int STAGES   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CH-1:0]    cfg_dir,
  input  logic [2*N_CH-1:0]  cfg_edge,
  input  logic [WW*N_CH-1:0] cfg_width,
  input  logic [N_CH-1:0]    pin_in,
  output logic [N_CH-1:0]    pin_out,
  output logic [N_CH-1:0]    pin_oe,
  input  logic [N_CH-1:0]    glb_in,
  output logic [N_CH-1:0]    glb_out
);
  // Internal events brought out for the checker
  logic [N_CH-1:0] in_evt;
  logic [N_CH-1:0] out_rise;

  for (genvar g = 0; g < N_CH; g++) begin : g_lane
    ext_clk_lane #(.WW(WW), .BASE_CYC(BASE_CYC), .STAGES(STAGES)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .dir   (cfg_dir[g]),
      .sel   (cfg_edge[2*g +: 2]),
      .width (cfg_width[WW*g +: WW]),
      .pin_i (pin_in[g]),
      .glb_i (glb_in[g]),
      .pin_o (pin_out[g]),
      .pin_en(pin_oe[g]),
      .glb_o (glb_out[g]),
      .evt   (in_evt[g]),
      .rise  (out_rise[g])
    );
  end
endmodule

// File: rtl/ext_clk_pins_chk.sv
module ext_clk_pins_chk #(
  parameter int N_CH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_CH-1:0]   cfg_dir,
  input logic [2*N_CH-1:0] cfg_edge,
  input logic [N_CH-1:0]   pin_out,
  input logic [N_CH-1:0]   glb_out,
  input logic [N_CH-1:0]   in_evt,
  input logic [N_CH-1:0]   out_rise
);
  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    // R10
    pin_idle_in_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_dir[g]) |-> !pin_out[g]);

    // R2
    glb_quiet_in_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_dir[g]) |-> !glb_out[g]);

    // R3
    strobe_from_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      glb_out[g] |-> $past(in_evt[g]));

    // R3
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_out[g] && !cfg_edge[2*g+1] && $stable(cfg_edge[2*g +: 2])) |=> !glb_out[g]);

    // R6
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_edge[2*g +: 2]) == 2'b11) |-> !glb_out[g]);

    // R8
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_rise[g] && cfg_dir[g]) |=> pin_out[g]);
  end
endmodule

bind ext_clk_pins ext_clk_pins_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_edge(cfg_edge),
  .pin_out(pin_out), .glb_out(glb_out), .in_evt(in_evt), .out_rise(out_rise)
);

// File: tb/tb_ext_clk_pins.sv
`timescale 1ns/1ps
module tb_ext_clk_pins;
  localparam int N  = 6;
  localparam int WW = 4;
  localparam int BASE = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]    cfg_dir;
  logic [2*N-1:0]  cfg_edge;
  logic [WW*N-1:0] cfg_width;
  logic [N-1:0]    pin_in, pin_out, pin_oe, glb_in, glb_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_clk_pins dut (
    .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_edge(cfg_edge),
    .cfg_width(cfg_width), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .glb_in(glb_in), .glb_out(glb_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  function automatic string edge_tag(int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Pin change driven just after a falling edge; strobe due at the 3rd falling edge
  task automatic edge_trial(input int ch, input int mode, input logic lvl);
    logic hit;
    hit = (mode == 2) || (mode == 0 && lvl) || (mode == 1 && !lvl);
    pin_in[ch] = lvl;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk(edge_tag(mode), 32'(glb_out), (k == 3 && hit) ? (32'd1 << ch) : 32'd0);
    end
  endtask

  // R8: pulse high at falling edges 1..BASE+w after the trigger is driven
  task automatic pulse_trial(input int ch, input int w);
    int len;
    len = BASE + w;
    cfg_width[ch*WW +: WW] = WW'(w);
    glb_in[ch] = 1'b1;
    for (int k = 1; k <= len + 3; k++) begin
      @(negedge clk);
      chk("R8", 32'(pin_out), (k <= len) ? (32'd1 << ch) : 32'd0);
      glb_in[ch] = 1'b0;
    end
  endtask

  initial begin
    int cnt;
    int len;
    logic [31:0] exp;
    rst_n = 1'b0; cfg_dir = '0; cfg_edge = '0; cfg_width = '0;
    pin_in = '0; glb_in = '0;
    repeat (4) @(negedge clk);
    chk("R1", 32'(glb_out), 0);
    chk("R1", 32'(pin_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 32'(glb_out), 0);
    chk("R1", 32'(pin_out), 0);

    // R2: direction sweep
    for (int d = 0; d < 64; d++) begin
      cfg_dir = N'(d);
      #1;
      chk("R2", 32'(pin_oe), 32'(d));
    end
    cfg_dir = '0;
    repeat (3) @(negedge clk);

    // R3..R6: every channel, every edge code, both directions of change
    for (int ch = 0; ch < N; ch++) begin
      for (int m = 0; m < 4; m++) begin
        cfg_edge = {N{2'(m)}};
        repeat (3) @(negedge clk);
        edge_trial(ch, m, 1'b1);
        edge_trial(ch, m, 1'b0);
      end
    end

    // R7: half-rate toggling, rising then both
    for (int m = 0; m <= 2; m += 2) begin
      cfg_edge = {N{2'(m)}};
      pin_in = '0;
      repeat (4) @(negedge clk);
      cnt = 0;
      for (int i = 0; i < 25; i++) begin
        @(negedge clk);
        if (glb_out[0]) cnt++;
        if (i < 20) pin_in[0] = ~pin_in[0];
      end
      chk("R7", 32'(cnt), (m == 0) ? 32'd10 : 32'd20);
    end
    cfg_edge = '0;

    // R8: output pulse widths on every channel
    cfg_dir = '1;
    repeat (3) @(negedge clk);
    for (int ch = 0; ch < N; ch++) begin
      pulse_trial(ch, 0);
      pulse_trial(ch, 1);
      pulse_trial(ch, 7);
      pulse_trial(ch, 15);
    end
    chk("R2", 32'(glb_out), 0);

    // R9: retrigger at k=4 on channel 2, width 3 (len 8): high through k=12
    cfg_width[2*WW +: WW] = 4'd3;
    len = BASE + 3;
    glb_in[2] = 1'b1;
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      chk("R9", 32'(pin_out), (k <= 4 + len) ? 32'd4 : 32'd0);
      glb_in[2] = (k == 4);
    end

    // R10: input-mode channel ignores its global line
    cfg_dir = '0;
    repeat (2) @(negedge clk);
    glb_in[0] = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk("R10", 32'(pin_out), 0);
      glb_in[0] = (k < 3);
    end
    glb_in = '0;
    // R10: switch to input mode mid-pulse
    cfg_dir = '1;
    cfg_width[0 +: WW] = 4'd15;
    repeat (2) @(negedge clk);
    glb_in[0] = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk("R10", 32'(pin_out), (k <= 2) ? 32'd1 : 32'd0);
      glb_in[0] = 1'b0;
      if (k == 2) cfg_dir[0] = 1'b0;
    end

    // R11: all channels triggered together, width 2*ch each
    cfg_dir = '1;
    for (int ch = 0; ch < N; ch++) cfg_width[ch*WW +: WW] = WW'(2 * ch);
    repeat (2) @(negedge clk);
    glb_in = '1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      exp = 0;
      for (int ch = 0; ch < N; ch++) if (k <= BASE + 2 * ch) exp[ch] = 1'b1;
      chk("R11", 32'(pin_out), exp);
      glb_in = '0;
    end

    finish_run();
  end
endmodule